// File: doc/BRIEF.md
# Programmable Address Window Detector

This block watches an address bus and raises a select line for each of several address windows. Every window has three settings that software loads at run time: a mask word, a compare word and an enable bit. Each address bit passes through a compare cell. The mask bit decides whether that bit is ignored or must equal the compare bit. The cells form a chain, so a window is selected only when every cell on the chain passes.

A global enable input gates every window at once. When more than one window is selected, the block also reports the lowest-numbered selected window as an encoded index, together with a valid flag. Configuration writes are registered. The window outputs themselves are combinational from the address, the global enable and the stored settings, so a decode completes in the same cycle as the address.

Top module: `addr_window_decoder`

## Requirements
- R1: While reset is asserted, and right after it is released, no window is selected, `hit_valid` is 0 and `hit_idx` is 0. Reset leaves every mask at all-ones, every compare word at zero and every window enable at 0.
- R2: When `dec_en` is 0, `win_sel` is all zeros and `hit_valid` is 0, whatever the address and the settings are.
- R3: A window whose enable bit is 0 is never selected.
- R4: An address bit whose mask bit is 0 does not affect that window's match.
- R5: An address bit whose mask bit is 1 must equal the matching compare bit for the window to match.
- R6: A window is selected only when `dec_en` is 1, its enable is 1 and every masked bit matches. A single mismatching bit deselects it.
- R7: A write with `cfg_we`=1 updates the field chosen by `cfg_field` (0 = mask word, 1 = compare word, 2 = enable, taken from `cfg_data` bit 0) of the window `cfg_idx` at the clock edge. The outputs show the new setting from the next cycle on, and the old setting during the write cycle.
- R8: A write with `cfg_idx` >= NUM_WIN, or with `cfg_field` = 3, changes no setting.
- R9: `hit_valid` is the OR of `win_sel`. `hit_idx` is the lowest index whose select is 1, and 0 when none is selected.
- R10: A write to one window leaves the settings of every other window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Global decode enable |
| addr | input | ADDR_W | Address under test |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Window targeted by the write |
| cfg_field | input | 2 | Field selector: 0 mask, 1 compare, 2 enable, 3 reserved |
| cfg_data | input | ADDR_W | Write data |
| win_sel | output | NUM_WIN | Per-window select |
| hit_valid | output | 1 | At least one window selected |
| hit_idx | output | IDX_W | Lowest selected window |

## Verification
The hardest case to reach from the ports is several windows matching one address with different masks, because a random address almost never satisfies a masked compare. The stimulus therefore programs overlapping windows on purpose: one exact match, one aligned range and one catch-all with an empty mask. It also draws many addresses from the model's own stored compare words, with the don't-care bits randomised. A behavioural model mirrors every write, including out-of-range indexes and the reserved field, and every cycle the bench compares the selects and the encoded winner against it.

// File: rtl/addr_window_pkg.sv
package addr_window_pkg;
    typedef enum logic [1:0] {
        FLD_MASK   = 2'd0,
        FLD_VALUE  = 2'd1,
        FLD_ENABLE = 2'd2,
        FLD_RSVD   = 2'd3
    } cfg_field_e;
endpackage

// File: rtl/awd_cmp_cell.sv
module awd_cmp_cell (
    input  logic chain_in,
    input  logic care,
    input  logic ref_bit,
    input  logic addr_bit,
    output logic chain_out
);
    // pass when disabled-by-mask, else require equality; gated by the chain
    always_comb begin
        chain_out = chain_in & (~care | ~(ref_bit ^ addr_bit));
    end
endmodule

// File: rtl/awd_window.sv
module awd_window #(
    parameter int ADDR_W = 16
) (
    input  logic              start,
    input  logic [ADDR_W-1:0] care_mask,
    input  logic [ADDR_W-1:0] ref_word,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W:0] chain;

    assign chain[0] = start;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_cell
        awd_cmp_cell u_cell (
            .chain_in (chain[b]),
            .care     (care_mask[b]),
            .ref_bit  (ref_word[b]),
            .addr_bit (addr[b]),
            .chain_out(chain[b+1])
        );
    end

    assign hit = chain[ADDR_W];
endmodule

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs
    import addr_window_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_WIN = 6,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic [1:0]                     cfg_field,
    input  logic [ADDR_W-1:0]              cfg_data,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] mask_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] value_o,
    output logic [NUM_WIN-1:0]             wen_o
);
    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] mask;
        logic [NUM_WIN-1:0][ADDR_W-1:0] value;
        logic [NUM_WIN-1:0]             wen;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    cfg_field_e fld;
    logic       idx_ok;

    always_comb begin
        fld     = cfg_field_e'(cfg_field);
        idx_ok  = (int'(cfg_idx) < NUM_WIN);
        state_d = state_q;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (cfg_we && idx_ok && (int'(cfg_idx) == w)) begin
                case (fld)
                    FLD_MASK:   state_d.mask[w]  = cfg_data;
                    FLD_VALUE:  state_d.value[w] = cfg_data;
                    FLD_ENABLE: state_d.wen[w]   = cfg_data[0];
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.mask  <= '1;
            state_q.value <= '0;
            state_q.wen   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o  = state_q.mask;
    assign value_o = state_q.value;
    assign wen_o   = state_q.wen;

    // R8: rejected writes leave every setting untouched
    assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (!idx_ok || cfg_field == 2'd3)) |=> $stable(state_q));

    // R10: a write never disturbs a window it does not target
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_iso
        assert_other_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(cfg_idx) != w) |=>
            ($stable(state_q.mask[w]) && $stable(state_q.value[w]) && $stable(state_q.wen[w])));
    end
endmodule

// File: rtl/awd_prio_enc.sv
module awd_prio_enc #(
    parameter int NUM_WIN = 6,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_WIN-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
    parameter  int ADDR_W  = 16,
    parameter  int NUM_WIN = 6,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [1:0]         cfg_field,
    input  logic [ADDR_W-1:0]  cfg_data,
    output logic [NUM_WIN-1:0] win_sel,
    output logic               hit_valid,
    output logic [IDX_W-1:0]   hit_idx
);
    logic [NUM_WIN-1:0][ADDR_W-1:0] mask_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] value_q;
    logic [NUM_WIN-1:0]             wen_q;

    awd_cfg_regs #(
        .ADDR_W (ADDR_W),
        .NUM_WIN(NUM_WIN),
        .IDX_W  (IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_field(cfg_field),
        .cfg_data (cfg_data),
        .mask_o   (mask_q),
        .value_o  (value_q),
        .wen_o    (wen_q)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        awd_window #(.ADDR_W(ADDR_W)) u_win (
            .start    (dec_en & wen_q[w]),
            .care_mask(mask_q[w]),
            .ref_word (value_q[w]),
            .addr     (addr),
            .hit      (win_sel[w])
        );

        // R3: a disabled window stays quiet
        assert_win_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !wen_q[w] |-> !win_sel[w]);
    end

    awd_prio_enc #(
        .NUM_WIN(NUM_WIN),
        .IDX_W  (IDX_W)
    ) u_enc (
        .req(win_sel),
        .any(hit_valid),
        .idx(hit_idx)
    );

    // R2: global enable low blanks every output
    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |-> (win_sel == '0 && !hit_valid));

    // R9: valid flag tracks the selects
    assert_valid_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid == (win_sel != '0));

    // R9: reported winner is selected and nothing below it is
    assert_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (win_sel[hit_idx] &&
                       ((win_sel & ~({NUM_WIN{1'b1}} << hit_idx)) == '0)));

    // R9: idle index reads zero
    assert_idle_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> hit_idx == '0);
endmodule

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
    localparam int AW = 16;
    localparam int NW = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [1:0]    cfg_field = '0;
    logic [AW-1:0] cfg_data = '0;
    logic [NW-1:0] win_sel;
    logic          hit_valid;
    logic [IW-1:0] hit_idx;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;
    string cur_req = "R1";

    logic [AW-1:0] m_mask [NW];
    logic [AW-1:0] m_val  [NW];
    logic          m_en   [NW];

    always #10 clk = ~clk;

    addr_window_decoder #(.ADDR_W(AW), .NUM_WIN(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .addr(addr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
        .cfg_data(cfg_data), .win_sel(win_sel), .hit_valid(hit_valid),
        .hit_idx(hit_idx)
    );

    // behavioural mirror of the settings
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                m_mask[w] <= 16'hFFFF;
                m_val[w]  <= 16'h0000;
                m_en[w]   <= 1'b0;
            end
        end else if (cfg_we && cfg_idx < NW) begin
            case (cfg_field)
                2'd0: m_mask[cfg_idx] <= cfg_data;
                2'd1: m_val[cfg_idx]  <= cfg_data;
                2'd2: m_en[cfg_idx]   <= cfg_data[0];
                default: ;
            endcase
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [NW-1:0] exp_sel;
            logic          exp_v;
            int            exp_i;
            exp_sel = '0;
            exp_v   = 1'b0;
            exp_i   = 0;
            for (int w = 0; w < NW; w++) begin
                bit ok;
                ok = dec_en && m_en[w];
                for (int b = 0; b < AW; b++)
                    if (m_mask[w][b] && (addr[b] != m_val[w][b])) ok = 0;
                exp_sel[w] = ok;
            end
            for (int w = NW - 1; w >= 0; w--)
                if (exp_sel[w]) begin exp_v = 1'b1; exp_i = w; end
            checks++;
            if (win_sel !== exp_sel || hit_valid !== exp_v || hit_idx !== IW'(exp_i)) begin
                fails++;
                $display("FAIL %s addr=%h sel=%b valid=%b idx=%0d expected sel=%b valid=%b idx=%0d",
                         cur_req, addr, win_sel, hit_valid, hit_idx, exp_sel, exp_v, exp_i);
            end
        end
    end

    task automatic wr(input int idx, input int fld, input logic [AW-1:0] data);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_field = 2'(fld); cfg_data = data;
    endtask

    task automatic look(input logic [AW-1:0] a, input logic en);
        @(posedge clk); #2;
        cfg_we = 1'b0; addr = a; dec_en = en;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        addr = 16'h0000; dec_en = 1'b1;
        @(posedge clk); #2; cmp_on = 1;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        look(16'h0000, 1); look(16'hFFFF, 1);
        @(negedge clk);
        checks++;
        if (win_sel !== '0 || hit_valid !== 1'b0 || hit_idx !== '0) begin
            fails++;
            $display("FAIL R1 after reset sel=%b valid=%b idx=%0d expected 0/0/0",
                     win_sel, hit_valid, hit_idx);
        end

        // R3: settings loaded but enable still 0
        cur_req = "R3";
        wr(0, 1, 16'h1234);
        look(16'h1234, 1);
        // R7: enable write takes effect one cycle later, addr held
        cur_req = "R7";
        wr(0, 2, 16'h0001);
        look(16'h1234, 1);
        @(negedge clk);
        checks++;
        if (win_sel[0] !== 1'b1) begin
            fails++;
            $display("FAIL R7 window0 sel=%b expected 1", win_sel[0]);
        end
        // R5 / R6: single differing bit rejects
        cur_req = "R5";
        look(16'h1235, 1); look(16'h9234, 1);
        cur_req = "R6";
        look(16'h1234, 1); look(16'h1230, 1);

        // R4: range window 0x4000..0x43FF
        cur_req = "R4";
        wr(1, 0, 16'hFC00); wr(1, 1, 16'h4000); wr(1, 2, 16'h0001);
        look(16'h4000, 1); look(16'h43FF, 1); look(16'h4155, 1); look(16'h4400, 1);
        look(16'h3FFF, 1);

        // R9: overlap with catch-all window 2 (empty mask)
        cur_req = "R9";
        wr(2, 0, 16'h0000); wr(2, 2, 16'h0001);
        look(16'h1234, 1); look(16'h4001, 1); look(16'h9999, 1);
        @(negedge clk);
        checks++;
        if (hit_idx !== 3'd2 || !hit_valid) begin
            fails++;
            $display("FAIL R9 idx=%0d valid=%b expected 2/1", hit_idx, hit_valid);
        end
        wr(5, 0, 16'h0000); wr(5, 2, 16'h0001);
        look(16'h1234, 1); look(16'hABCD, 1);

        // R2: global enable off
        cur_req = "R2";
        look(16'h1234, 0); look(16'h4001, 0); look(16'h0000, 0);

        // R8: out-of-range index and reserved field
        cur_req = "R8";
        wr(6, 0, 16'h0000); wr(7, 2, 16'h0000); wr(0, 3, 16'h0000); wr(1, 3, 16'hFFFF);
        look(16'h1234, 1); look(16'h4001, 1); look(16'h1235, 1);

        // R10: random writes and addresses against the mirror
        cur_req = "R10";
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 5;
            if (r == 0) begin
                wr($urandom % 8, $urandom % 4,
                   ($urandom % 3 == 0) ? 16'(($urandom % 16) << 12) : 16'($urandom));
            end else if (r == 1) begin
                look(16'($urandom), ($urandom % 6) != 0);
            end else begin
                int k;
                k = $urandom % NW;
                look(m_val[k] ^ (16'($urandom) & ~m_mask[k]), ($urandom % 6) != 0);
            end
        end
        look(16'h0000, 1);
        @(negedge clk);
        finish_run();
    end
endmodule